// File: doc/BRIEF.md
# Segment Blink Controller

This block holds the on/off state of every segment of a multiplexed display in two bit planes. One plane holds the display bits. The other holds a blink-enable bit per segment. A host reaches both planes through a single window of word addresses on a plain register bus. A select bit in the control word decides which plane that window maps to. A second control bit makes every segment blink, whatever either plane holds, but only while the window points at the blink plane.

A slow tick from the clock tree toggles an internal blink phase. The control word also holds a 3-bit rate code, and the block drives that code out to the tick source. The per-segment drive vector is registered and updated only on a frame-boundary strobe, so the glass never changes in the middle of a frame. While the low-power stop flag is high, host writes are dropped. Blinking and frame updates continue during stop.

The register bus and the segment vector are plain control paths with no valid/ready handshake. A write is accepted in the cycle it is presented, and read data is valid combinationally in the same cycle. No back-pressure is possible on either side.

Top module: `seg_blink_ctrl`

## Requirements
- R1: After reset, seg_out is all zeros, both planes and the control word read as zero, and the blink phase is "on".
- R2: With control bit 0 clear, addresses 0 to NUM_SEG/BUS_W-1 read and write the display plane. Word k bit b is segment k*BUS_W+b.
- R3: With control bit 0 set, the same addresses read and write the blink-enable plane, and the display plane keeps its contents.
- R4: The control word sits at address NUM_SEG/BUS_W. Bit 0 is the plane select, bit 1 is global blink, and bits 4:2 are the rate code. It reads back as written, and rate_sel always equals bits 4:2.
- R5: Each blink_tick pulse toggles the blink phase between "on" and "off".
- R6: In the "off" phase, a segment with its blink enabled is driven 0. In the "on" phase, every segment is driven with its display bit.
- R7: A segment with blink disabled is driven with its display bit in both phases.
- R8: When global blink and plane select are both set, every segment counts as blink-enabled. Global blink with plane select clear has no effect.
- R9: seg_out changes only in the cycle after a frame_tick. It samples the phase and plane contents present at that edge.
- R10: While stop is high, host writes to the planes and the control word are ignored, but blink ticks and frame updates still act.
- R11: Addresses above the control word read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | BUS_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | BUS_W | Read data for bus_addr |
| blink_tick | input | 1 | One-cycle pulse from the blink-rate divider |
| frame_tick | input | 1 | One-cycle pulse at each frame boundary |
| stop | input | 1 | Low-power stop flag |
| rate_sel | output | 3 | Blink rate code for the tick source |
| seg_out | output | NUM_SEG | Per-segment drive value |

## Verification
A wrong blink phase is visible only in segments with blink enabled, and only after the next frame strobe. For that reason the vectors mix enabled and disabled segments and count the ticks between frames. A wrong plane mapping shows at the first readback after a select change, and at the next frame as a display pattern that was never written. A lost or stray update shows one cycle after a frame strobe, or as a change on seg_out without any strobe.

// File: rtl/seg_blink_pkg.sv
package seg_blink_pkg;
  localparam int RATE_W = 3;
  localparam int CTRL_W = RATE_W + 2;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              global_blk;
    logic              plane_sel;
  } ctrl_t;
endpackage

// File: rtl/seg_plane_ram.sv
module seg_plane_ram #(
  parameter int WORDS = 4,
  parameter int W     = 8,
  parameter int AW    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [W-1:0]       wr_data,
  output logic [W-1:0]       rd_word,
  output logic [WORDS*W-1:0] bits
);
  logic [WORDS-1:0][W-1:0] mem;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[g] <= '0;
      else if (wr_en && addr == AW'(g)) mem[g] <= wr_data;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < WORDS; k++)
      if (addr == AW'(k)) rd_word = mem[k];
  end

  assign bits = mem;

  p_plane_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem));
endmodule

// File: rtl/seg_blink_phase.sv
module seg_blink_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic phase_off
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_off <= 1'b0;
    else if (tick) phase_off <= ~phase_off;
  end

  p_phase_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> phase_off != $past(phase_off));
  p_phase_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase_off));
endmodule

// File: rtl/seg_frame_mux.sv
module seg_frame_mux #(
  parameter int NUM_SEG = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame,
  input  logic [NUM_SEG-1:0] disp,
  input  logic [NUM_SEG-1:0] blink_en,
  input  logic               all_blink,
  input  logic               phase_off,
  output logic [NUM_SEG-1:0] seg_out
);
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic blank;
    assign blank = phase_off & (blink_en[s] | all_blink);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seg_out[s] <= 1'b0;
      else if (frame) seg_out[s] <= disp[s] & ~blank;
    end
  end

  p_frame_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame |=> $stable(seg_out));
endmodule

// File: rtl/seg_blink_ctrl.sv
module seg_blink_ctrl
  import seg_blink_pkg::*;
#(
  parameter int NUM_SEG = 32,
  parameter int BUS_W   = 8,
  parameter int ADDR_W  = $clog2(NUM_SEG / BUS_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  input  logic               bus_we,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic               blink_tick,
  input  logic               frame_tick,
  input  logic               stop,
  output logic [RATE_W-1:0]  rate_sel,
  output logic [NUM_SEG-1:0] seg_out
);
  localparam int WORDS = NUM_SEG / BUS_W;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(WORDS);

  ctrl_t              ctrl_q;
  logic               wr_ok;
  logic [BUS_W-1:0]   disp_rd, blink_rd;
  logic [NUM_SEG-1:0] disp_bits, blink_bits;
  logic               phase_off;
  logic               all_blink;

  assign wr_ok     = bus_we & ~stop;
  assign all_blink = ctrl_q.global_blk & ctrl_q.plane_sel;
  assign rate_sel  = ctrl_q.rate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_ok && bus_addr == CTRL_ADDR) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  seg_plane_ram #(.WORDS(WORDS), .W(BUS_W), .AW(ADDR_W)) u_disp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok & ~ctrl_q.plane_sel),
    .addr(bus_addr), .wr_data(bus_wdata), .rd_word(disp_rd), .bits(disp_bits));

  seg_plane_ram #(.WORDS(WORDS), .W(BUS_W), .AW(ADDR_W)) u_blink (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok & ctrl_q.plane_sel),
    .addr(bus_addr), .wr_data(bus_wdata), .rd_word(blink_rd), .bits(blink_bits));

  seg_blink_phase u_phase (
    .clk(clk), .rst_n(rst_n), .tick(blink_tick), .phase_off(phase_off));

  seg_frame_mux #(.NUM_SEG(NUM_SEG)) u_mux (
    .clk(clk), .rst_n(rst_n), .frame(frame_tick), .disp(disp_bits),
    .blink_en(blink_bits), .all_blink(all_blink), .phase_off(phase_off),
    .seg_out(seg_out));

  always_comb begin
    if (bus_addr < CTRL_ADDR)
      bus_rdata = ctrl_q.plane_sel ? blink_rd : disp_rd;
    else if (bus_addr == CTRL_ADDR)
      bus_rdata = BUS_W'(ctrl_q);
    else
      bus_rdata = '0;
  end

  p_global_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && phase_off && all_blink) |=> seg_out == '0);
  p_on_phase_shows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !phase_off) |=> seg_out == $past(disp_bits));
  p_stop_ctrl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> $stable(ctrl_q));
  p_rate_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rate_sel == ctrl_q.rate);
endmodule

// File: tb/seg_blink_ctrl_tb.sv
module seg_blink_ctrl_tb;
  localparam int NS = 32;
  localparam int BW = 8;
  localparam int AW = 3;
  localparam int NW = NS / BW;
  localparam int NV = 6;

  localparam logic [NS-1:0] V_DISP  [NV] = '{32'hA5A5_F00F, 32'hA5A5_F00F, 32'hFFFF_FFFF,
                                             32'h0F0F_0F0F, 32'h8000_0001, 32'hCAFE_BABE};
  localparam logic [NS-1:0] V_BLINK [NV] = '{32'h0000_FFFF, 32'h0000_FFFF, 32'h1234_5678,
                                             32'h0000_0000, 32'h8000_0000, 32'hFFFF_0000};
  localparam logic          V_GLB   [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam int            V_TICKS [NV] = '{0, 1, 2, 1, 1, 0};

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [BW-1:0] bus_wdata = '0, bus_rdata;
  logic bus_we = 0, blink_tick = 0, frame_tick = 0, stop = 0;
  logic [2:0] rate_sel;
  logic [NS-1:0] seg_out;
  int n_run = 0, n_fail = 0;
  bit tb_off = 0;

  always #5 clk = ~clk;

  seg_blink_ctrl #(.NUM_SEG(NS), .BUS_W(BW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .blink_tick(blink_tick),
    .frame_tick(frame_tick), .stop(stop), .rate_sel(rate_sel), .seg_out(seg_out));

  task automatic check(string req, logic [NS-1:0] got, logic [NS-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [BW-1:0] d);
    @(negedge clk); bus_addr = AW'(a); bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(int a, output logic [BW-1:0] d);
    @(negedge clk); bus_addr = AW'(a); #1 d = bus_rdata;
  endtask

  task automatic wr_plane(logic [NS-1:0] v);
    for (int k = 0; k < NW; k++) wr(k, v[k*BW +: BW]);
  endtask

  task automatic tick();
    @(negedge clk); blink_tick = 1; @(negedge clk); blink_tick = 0; tb_off = ~tb_off;
  endtask

  task automatic frame();
    @(negedge clk); frame_tick = 1; @(negedge clk); frame_tick = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [BW-1:0] r;
    logic [NS-1:0] eb, exp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 seg_out", seg_out, '0);
    rd(NW, r); check("R1 ctrl", NS'(r), '0);
    rd(0, r);  check("R1 disp word", NS'(r), '0);
    check("R1 rate_sel", NS'(rate_sel), '0);

    // Vector table loop (R5 R6 R7 R8)
    for (int i = 0; i < NV; i++) begin
      wr(NW, 8'h00);
      wr_plane(V_DISP[i]);
      wr(NW, 8'h01);
      wr_plane(V_BLINK[i]);
      wr(NW, {6'b0, V_GLB[i], 1'b1});
      for (int t = 0; t < V_TICKS[i]; t++) tick();
      frame();
      eb  = V_GLB[i] ? '1 : V_BLINK[i];
      exp = tb_off ? (V_DISP[i] & ~eb) : V_DISP[i];
      check($sformatf("R6/R7/R8 vector %0d", i), seg_out, exp);
    end

    // R2 R3 plane mapping
    wr(NW, 8'h00); wr(0, 8'h3C); rd(0, r); check("R2 disp readback", NS'(r), NS'(8'h3C));
    wr(NW, 8'h01); wr(0, 8'hC3); rd(0, r); check("R3 blink readback", NS'(r), NS'(8'hC3));
    wr(NW, 8'h00); rd(0, r); check("R3 disp untouched", NS'(r), NS'(8'h3C));

    // R4 control word
    wr(NW, 8'h1D); rd(NW, r); check("R4 ctrl readback", NS'(r), NS'(8'h1D));
    check("R4 rate_sel", NS'(rate_sel), NS'(3'd7));

    // R11 unmapped addresses
    wr(NW, 8'h00); wr(NW + 2, 8'hFF); rd(NW + 2, r); check("R11 unmapped read", NS'(r), '0);
    rd(NW, r); check("R11 ctrl untouched", NS'(r), '0);
    rd(1, r);  check("R11 plane untouched", NS'(r), NS'(V_DISP[NV-1][BW +: BW]));

    // R8 global bit with plane select clear has no effect
    wr_plane('1); wr(NW, 8'h01); wr_plane('0); wr(NW, 8'h02);
    if (!tb_off) tick();
    frame(); check("R8 global ignored w/o select", seg_out, '1);

    // R9 no update without frame
    wr(NW, 8'h00); wr(0, 8'h00);
    repeat (3) @(negedge clk);
    check("R9 hold without frame", seg_out, '1);
    frame(); check("R9 update at frame", seg_out, {{(NS-BW){1'b1}}, 8'h00});

    // R10 stop: writes ignored, blink continues
    wr(NW, 8'h01); wr_plane('1); wr(NW, 8'h00);   // all blink-enabled, display all ones
    wr_plane('1);
    if (tb_off) tick();
    frame(); check("R10 on-phase before stop", seg_out, '1);
    stop = 1;
    wr(0, 8'h00); wr(NW, 8'h1F);
    tick(); frame();
    check("R10 blink in stop", seg_out, '0);
    tick(); frame();
    check("R10 frame in stop", seg_out, '1);
    stop = 0;
    rd(0, r);  check("R10 plane write ignored", NS'(r), NS'(8'hFF));
    rd(NW, r); check("R10 ctrl write ignored", NS'(r), '0);

    finish_run();
  end
endmodule